// File: doc/BRIEF.md
# Narrow Multiplexed Memory Bus Sequencer

This block sits between a 12-bit processor core and a narrow external bus made of one 8-bit output port and one 4-bit input port. Each core transfer carries a 12-bit address and 12 bits of data. The block sends them as a fixed train of tagged bytes, one byte per clock. First come two address bytes of six bits each. An I/O transfer then adds one introduction byte. Last come three data bytes of one nibble each.

The core raises a request strobe while the sequencer is idle. With it, the core supplies the direction, an I/O flag with a 5-bit I/O code, the address and the write data. All of these are latched when the request is accepted. On a read, the block assembles the three nibbles returned on the input port into a 12-bit word. It signals completion with a one-cycle done pulse. It also takes one sample of the external interrupt line per transfer and holds it for the core.

Top module: `nbus_seq`

## Requirements
- R1: After synchronous active-high reset, `busOut` is 8'h00, `done` is 0, `rdData` is 0 and `irqSampled` is 0. While idle, `busOut` stays 8'h00.
- R2: A request accepted at a clock edge produces the high address byte `{2'b10, addr[11:6]}` in the next cycle. The low address byte `{2'b11, addr[5:0]}` follows in the cycle after that.
- R3: For an I/O transfer, the byte after the low address byte is `{3'b011, ioCode[4:0]}`. Here ioCode[4:3] is the I/O field and ioCode[2:0] holds the pulse flags with weights 4, 2 and 1. A memory transfer has no such byte.
- R4: Three data bytes follow in consecutive cycles, with tag bits [7:5] equal to 000, then 001, then 010. A memory transfer therefore lasts 5 beats and an I/O transfer lasts 6.
- R5: Bit 4 of a data byte is 1 for a write and 0 for a read. On a write, bits [3:0] carry wdata[11:8], wdata[7:4] and wdata[3:0] in turn. On a read, bits [3:0] are driven as 4'hF.
- R6: On a read, the `busIn` values present during the high, middle and low data beats become rdData[11:8], rdData[7:4] and rdData[3:0].
- R7: `done` is high for exactly one cycle: the cycle after the low data beat. In that cycle `rdData` holds the new word and `busOut` is 8'h00.
- R8: `busIn` is ignored outside read data beats. A write transfer leaves `rdData` unchanged.
- R9: `irqIn` is sampled only at the end of the high address beat. `irqSampled` shows that value from the next cycle on and holds it until the next transfer's high address beat.
- R10: A request raised while a transfer is in progress is ignored. Changes to the address, data, direction or code inputs after acceptance do not affect the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Transfer request, accepted only while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O transfer with introduction byte |
| ioCode | input | 5 | I/O field [4:3] and pulse flags [2:0] |
| reqAddr | input | 12 | Transfer address |
| reqWdata | input | 12 | Write data |
| busIn | input | 4 | External nibble input |
| irqIn | input | 1 | External interrupt request |
| busOut | output | 8 | Tagged beat byte |
| rdData | output | 12 | Assembled read word |
| done | output | 1 | One-cycle completion pulse |
| irqSampled | output | 1 | Interrupt level held from the last high address beat |

## Verification
The assertions check the byte ordering on every cycle. High address is always followed by low address, low address by an I/O byte or the high data nibble, and the data tags by one another. They also check that done follows the low data beat for exactly one cycle with an idle bus, that the low read nibble is captured, that write beats leave the read word alone, and that the interrupt sample changes only after a high address beat. Only the bench scenarios can show the complete byte values against the latched address, code and write data. The same holds for the full three-nibble read assembly and for the immunity to request and input changes during a transfer.

// File: rtl/nbus_pkg.sv
package nbus_pkg;
  typedef enum logic [2:0] {
    BEAT_IDLE = 3'd0,
    BEAT_AHI  = 3'd1,
    BEAT_ALO  = 3'd2,
    BEAT_IO   = 3'd3,
    BEAT_DHI  = 3'd4,
    BEAT_DMID = 3'd5,
    BEAT_DLO  = 3'd6
  } beatT;

  typedef struct packed {
    logic       accept;
    logic       sampleIrq;
    logic [2:0] capNib;   // [2]=high, [1]=mid, [0]=low nibble beat
    logic       finish;
    beatT       beat;
  } strobeT;
endpackage

// File: rtl/nbus_ctrl.sv
module nbus_ctrl
  import nbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   reqIo,
  output strobeT stb
);
  beatT state, stateNext;
  logic ioQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BEAT_IDLE;
      ioQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.accept) ioQ <= reqIo;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      BEAT_IDLE: if (reqValid) stateNext = BEAT_AHI;
      BEAT_AHI:  stateNext = BEAT_ALO;
      BEAT_ALO:  stateNext = ioQ ? BEAT_IO : BEAT_DHI;
      BEAT_IO:   stateNext = BEAT_DHI;
      BEAT_DHI:  stateNext = BEAT_DMID;
      BEAT_DMID: stateNext = BEAT_DLO;
      BEAT_DLO:  stateNext = BEAT_IDLE;
      default:   stateNext = BEAT_IDLE;
    endcase
  end

  always_comb begin
    stb.accept    = (state == BEAT_IDLE) && reqValid;
    stb.sampleIrq = (state == BEAT_AHI);
    stb.capNib    = {state == BEAT_DHI, state == BEAT_DMID, state == BEAT_DLO};
    stb.finish    = (state == BEAT_DLO);
    stb.beat      = state;
  end
endmodule

// File: rtl/nbus_dpath.sv
module nbus_dpath
  import nbus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            stb,
  input  logic              reqWrite,
  input  logic [CODE_W-1:0] ioCode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [3:0]        busIn,
  input  logic              irqIn,
  output logic [7:0]        busOut,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              irqSampled
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int NIB_W  = DATA_W / 3;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic [DATA_W-1:0] rdAcc;
  logic [CODE_W-1:0] codeQ;
  logic              wrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      wdQ   <= '0;
      codeQ <= '0;
      wrQ   <= 1'b0;
    end else if (stb.accept) begin
      addrQ <= reqAddr;
      wdQ   <= reqWdata;
      codeQ <= ioCode;
      wrQ   <= reqWrite;
    end
  end

  // read nibble assembly, one slice per data beat
  for (genvar k = 0; k < 3; k++) begin : g_nib
    if (k == 0) begin : g_last
      always_ff @(posedge clk) begin
        if (rst) rdData <= '0;
        else if (stb.capNib[0] && !wrQ)
          rdData <= {rdAcc[DATA_W-1:NIB_W], busIn};
      end
      assign rdAcc[NIB_W-1:0] = '0;
    end else begin : g_acc
      always_ff @(posedge clk) begin
        if (rst) rdAcc[k*NIB_W +: NIB_W] <= '0;
        else if (stb.capNib[k] && !wrQ)
          rdAcc[k*NIB_W +: NIB_W] <= busIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      irqSampled <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.sampleIrq) irqSampled <= irqIn;
    end
  end

  function automatic logic [7:0] dataBeat(input logic [2:0] tag, input int idx);
    logic [3:0] nib;
    nib = wrQ ? wdQ[idx*NIB_W +: NIB_W] : 4'hF;
    return {tag, wrQ, nib};
  endfunction

  always_comb begin
    unique case (stb.beat)
      BEAT_AHI:  busOut = {2'b10, addrQ[ADDR_W-1:HALF_W]};
      BEAT_ALO:  busOut = {2'b11, addrQ[HALF_W-1:0]};
      BEAT_IO:   busOut = {3'b011, codeQ};
      BEAT_DHI:  busOut = dataBeat(3'b000, 2);
      BEAT_DMID: busOut = dataBeat(3'b001, 1);
      BEAT_DLO:  busOut = dataBeat(3'b010, 0);
      default:   busOut = 8'h00;
    endcase
  end
endmodule

// File: rtl/nbus_seq.sv
module nbus_seq
  import nbus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic [CODE_W-1:0] ioCode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [3:0]        busIn,
  input  logic              irqIn,
  output logic [7:0]        busOut,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              irqSampled
);
  strobeT stb;

  nbus_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqIo    (reqIo),
    .stb      (stb)
  );

  nbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .reqWrite   (reqWrite),
    .ioCode     (ioCode),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .busIn      (busIn),
    .irqIn      (irqIn),
    .busOut     (busOut),
    .rdData     (rdData),
    .done       (done),
    .irqSampled (irqSampled)
  );
endmodule

// File: rtl/nbus_seq_chk.sv
module nbus_seq_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        busIn,
  input logic [7:0]        busOut,
  input logic [DATA_W-1:0] rdData,
  input logic              done,
  input logic              irqSampled
);
  logic isAhi, isAlo, isIo, isDhi, isDmid, isDlo, isWrBeat;
  assign isAhi    = busOut[7:6] == 2'b10;
  assign isAlo    = busOut[7:6] == 2'b11;
  assign isIo     = busOut[7:5] == 3'b011;
  assign isDhi    = (busOut[7:5] == 3'b000) && (busOut != 8'h00);
  assign isDmid   = busOut[7:5] == 3'b001;
  assign isDlo    = busOut[7:5] == 3'b010;
  assign isWrBeat = (isDhi || isDmid || isDlo) && busOut[4];

  AST_DONE_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    done |-> busOut == 8'h00); // R1
  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (rst)
    isAhi |=> isAlo); // R2
  AST_AFTER_ALO: assert property (@(posedge clk) disable iff (rst)
    isAlo |=> (isIo || isDhi)); // R3
  AST_IO_TO_DATA: assert property (@(posedge clk) disable iff (rst)
    isIo |=> isDhi); // R3
  AST_HI_TO_MID: assert property (@(posedge clk) disable iff (rst)
    isDhi |=> isDmid); // R4
  AST_MID_TO_LO: assert property (@(posedge clk) disable iff (rst)
    isDmid |=> isDlo); // R4
  AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (isDlo && !busOut[4]) |=> rdData[3:0] == $past(busIn)); // R6
  AST_DONE_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
    isDlo |=> done); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_WRITE_KEEPS_RD: assert property (@(posedge clk) disable iff (rst)
    isWrBeat |=> $stable(rdData)); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !isAhi |=> $stable(irqSampled)); // R9
endmodule

bind nbus_seq nbus_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busIn      (busIn),
  .busOut     (busOut),
  .rdData     (rdData),
  .done       (done),
  .irqSampled (irqSampled)
);

// File: tb/nbus_seq_tb.sv
module nbus_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0, irqIn = 1'b0;
  logic [4:0]  ioCode = '0;
  logic [11:0] reqAddr = '0, reqWdata = '0;
  logic [3:0]  busIn = '0;
  logic [7:0]  busOut;
  logic [11:0] rdData;
  logic        done, irqSampled;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [11:0] expRd = '0;

  always #10 clk = ~clk;

  nbus_seq u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqIo(reqIo),
    .ioCode(ioCode), .reqAddr(reqAddr), .reqWdata(reqWdata), .busIn(busIn),
    .irqIn(irqIn), .busOut(busOut), .rdData(rdData), .done(done),
    .irqSampled(irqSampled)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expBeat(input int idx, input bit wr, input bit io,
                                         input logic [4:0] code, input logic [11:0] a,
                                         input logic [11:0] wd);
    int d;
    if (idx == 0) return {2'b10, a[11:6]};
    if (idx == 1) return {2'b11, a[5:0]};
    if (io && idx == 2) return {3'b011, code};
    d = io ? idx - 3 : idx - 2;
    return {d[2:0], wr, wr ? wd[(2-d)*4 +: 4] : 4'hF};
  endfunction

  task automatic xfer(input bit wr, input bit io, input logic [4:0] code,
                      input logic [11:0] a, input logic [11:0] wd, input bit irqV);
    int n;
    int d;
    logic [3:0] nib;
    n = io ? 6 : 5;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqIo = io; ioCode = code;
    reqAddr = a; reqWdata = wd; irqIn = ~irqV;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // R10: scramble request inputs after acceptance, re-raise request while busy
      reqValid = (i == 1); reqWrite = $urandom; reqIo = $urandom;
      ioCode = $urandom; reqAddr = $urandom; reqWdata = $urandom;
      irqIn = (i == 0) ? irqV : 1'($urandom);
      nib = $urandom; busIn = nib;
      if (i == 0)      check(busOut == expBeat(i, wr, io, code, a, wd), "R2", busOut, expBeat(i, wr, io, code, a, wd));
      else if (i == 1) check(busOut == expBeat(i, wr, io, code, a, wd), "R2/R10", busOut, expBeat(i, wr, io, code, a, wd));
      else if (io && i == 2) check(busOut == expBeat(i, wr, io, code, a, wd), "R3", busOut, expBeat(i, wr, io, code, a, wd));
      else check(busOut == expBeat(i, wr, io, code, a, wd), "R4/R5", busOut, expBeat(i, wr, io, code, a, wd));
      if (i == 1) check(irqSampled == irqV, "R9", irqSampled, irqV);
      d = io ? i - 3 : i - 2;
      if (!wr && d >= 0) expRd[(2-d)*4 +: 4] = nib;
    end
    @(negedge clk);
    reqValid = 1'b0; busIn = $urandom; irqIn = $urandom;
    check(done == 1'b1, "R7", done, 1);
    check(rdData == expRd, wr ? "R8" : "R6", rdData, expRd);
    check(busOut == 8'h00, "R1", busOut, 0);
    check(irqSampled == irqV, "R9", irqSampled, irqV);
    @(negedge clk);
    check(done == 1'b0, "R7", done, 0);
    check(busOut == 8'h00 && rdData == expRd, "R1/R8", {busOut, rdData}, {8'h00, expRd});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=expired expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busOut == 8'h00 && done == 1'b0, "R1", {busOut, done}, 0);
    check(rdData == 12'h000 && irqSampled == 1'b0, "R1", {rdData, irqSampled}, 0);
    @(negedge clk);
    rst = 1'b0;
    // R8: noise on busIn while idle must not reach rdData
    repeat (3) begin
      @(negedge clk); busIn = $urandom;
      check(rdData == 12'h000 && busOut == 8'h00, "R8", rdData, 0);
    end
    xfer(1'b0, 1'b0, 5'h00, 12'h000, 12'h000, 1'b1);
    xfer(1'b0, 1'b0, 5'h00, 12'hFFF, 12'h000, 1'b0);
    xfer(1'b1, 1'b0, 5'h00, 12'hA5C, 12'hFFF, 1'b1);
    xfer(1'b1, 1'b0, 5'h00, 12'h03F, 12'h000, 1'b0);
    xfer(1'b0, 1'b1, 5'h1F, 12'hFC0, 12'h000, 1'b1);
    xfer(1'b1, 1'b1, 5'h00, 12'h123, 12'h9A6, 1'b0);
    for (int t = 0; t < 60; t++)
      xfer(1'($urandom), 1'($urandom), 5'($urandom), 12'($urandom), 12'($urandom), 1'($urandom));
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule